// File: doc/BRIEF.md
# Super-Frame Pixel Intensity Modulator

This block turns per-pixel brightness codes into column enables for a row-multiplexed LED matrix with two colour planes (red, also digit 0, and green, also digit 1). Each pixel carries a 2-bit code. A super frame of twelve complete scans maps each code to an on/off pattern. Twelve frames is the least common multiple of three and four, so a one-third scale and a one-quarter scale can run side by side on the same driver. Each colour plane picks its own scale, arithmetic or geometric.

Inside each row slot the block also runs an amplitude PWM. A shared panel level sets the on-time of the panel gate. Each digit's own 8-bit scale factor cuts that on-time further, to floor(panel x digit / 256) phase steps. The host side supplies the codes for the row the block reports, and the block advances its phase, row and frame counters on every step strobe. A configuration strobe loads the panel level, both digit scales and both scale selects together.

Top module: `superframe_modulator`

## Requirements
- R1: After reset the phase, row (`row_o`) and frame (`frame_o`) are 0. The configuration holds panel level 128, both digit scales 255, and the arithmetic scale on both planes.
- R2: Each cycle with `step_i` high advances the phase (0..255). A step taken at phase 255 advances the row (0..7, wrapping 7 to 0). A step that wraps the row advances the frame (0..11, wrapping 11 to 0).
- R3: Code 2'b11 is on in all twelve frames and code 2'b00 is off in all twelve frames, on either scale.
- R4: On the arithmetic scale (select 0), code 2'b10 is on when frame mod 3 is 0 or 2. Code 2'b01 is on when frame mod 3 is 1.
- R5: On the geometric scale (select 1), code 2'b10 is on in even frames. Code 2'b01 is on when frame mod 4 is 1.
- R6: The red plane uses the red scale select and the green plane uses the green scale select, each independently of the other.
- R7: `pwm_gate_o` is high exactly when the phase is below the panel level, so a panel level of 0 never opens it.
- R8: Column c of a plane is enabled only when its pattern bit for the current frame is on and the phase is below floor(panel x digit / 256). The digit is scale 0 for red and scale 1 for green.
- R9: With `two_bit_i` low, bit 2c of the code bus alone gives pixel c: set means full on, clear means off, and bit 2c+1 is ignored. With `two_bit_i` high, bits 2c+1:2c form the code of pixel c.
- R10: With `step_i` low, the phase, row and frame hold.
- R11: A cycle with `cfg_we_i` high loads all five configuration inputs at once, taking effect on the next cycle. Without it, changes on those inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Multiplex clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Advances the PWM phase by one step |
| cfg_we_i | input | 1 | Loads the five configuration inputs |
| panel_lvl_i | input | 8 | Panel PWM level |
| dig0_scale_i | input | 8 | Red (digit 0) scale factor |
| dig1_scale_i | input | 8 | Green (digit 1) scale factor |
| red_geo_i | input | 1 | Red plane scale: 0 arithmetic, 1 geometric |
| grn_geo_i | input | 1 | Green plane scale: 0 arithmetic, 1 geometric |
| two_bit_i | input | 1 | 1: 2-bit codes, 0: 1-bit pixels |
| red_code_i | input | 16 | Red codes of the current row, pixel c at bits 2c+1:2c |
| grn_code_i | input | 16 | Green codes of the current row, same layout |
| row_o | output | 3 | Current row |
| frame_o | output | 4 | Current frame within the super frame |
| pwm_gate_o | output | 1 | Panel PWM gate |
| red_en_o | output | 8 | Red column enables |
| grn_en_o | output | 8 | Green column enables |

## Verification
The bench walks complete super frames, so every frame index meets every code on both scales. A design that swapped the one-third and one-quarter patterns, or shared one scale select between the planes, would light pixels in the wrong frames. The bench also drives the level corners: panel 0, panel 255 with digit 255 (on-time 254), and small digit factors. A mistake in the product truncation would show there as an enable that lasts one step too long or too short. It also checks wrap points (phase 255, row 7, frame 11), stalls of the step strobe, configuration inputs that change without the load strobe, and 1-bit mode with noise on the ignored upper code bits.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

  localparam int SUPER_LEN = 12;
  localparam int FRAME_W   = $clog2(SUPER_LEN);

  typedef enum logic {
    SCALE_ARITH = 1'b0,
    SCALE_GEO   = 1'b1
  } scale_e;

  // Frame-modulation decision for one pixel code in one frame of the super frame.
  function automatic logic frame_pattern(input logic [1:0] code,
                                         input scale_e sc,
                                         input logic [FRAME_W-1:0] fr);
    logic [FRAME_W-1:0] r3;
    logic on;
    r3 = fr % FRAME_W'(3);
    case (code)
      2'b11:   on = 1'b1;
      2'b10:   on = (sc == SCALE_GEO) ? ~fr[0] : (r3 != FRAME_W'(1));
      2'b01:   on = (sc == SCALE_GEO) ? (fr[1:0] == 2'b01) : (r3 == FRAME_W'(1));
      default: on = 1'b0;
    endcase
    return on;
  endfunction

endpackage

// File: rtl/sfm_scan_ctr.sv
module sfm_scan_ctr
  import sfm_pkg::*;
#(
  parameter int PH_W = 8,
  parameter int ROWS = 8,
  localparam int RW  = $clog2(ROWS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_i,
  output logic [PH_W-1:0]    phase_o,
  output logic [RW-1:0]      row_o,
  output logic [FRAME_W-1:0] frame_o
);

  logic [PH_W-1:0]    phase_q;
  logic [RW-1:0]      row_q;
  logic [FRAME_W-1:0] frame_q;

  logic phase_last, row_last, frame_last;
  logic row_wrap, frame_wrap, super_wrap;

  assign phase_last = (phase_q == {PH_W{1'b1}});
  assign row_last   = (row_q == RW'(ROWS - 1));
  assign frame_last = (frame_q == FRAME_W'(SUPER_LEN - 1));

  // named scan events
  assign row_wrap   = step_i & phase_last;
  assign frame_wrap = row_wrap & row_last;
  assign super_wrap = frame_wrap & frame_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      row_q   <= '0;
      frame_q <= '0;
    end else if (step_i) begin
      phase_q <= phase_q + 1'b1;
      if (phase_last) begin
        row_q <= row_last ? '0 : row_q + 1'b1;
        if (row_last) begin
          frame_q <= frame_last ? '0 : frame_q + 1'b1;
        end
      end
    end
  end

  assign phase_o = phase_q;
  assign row_o   = row_q;
  assign frame_o = frame_q;

  AST_FRAME_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_q < FRAME_W'(SUPER_LEN)); // R2
  AST_ROW_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (row_wrap && !row_last) |=> (row_q == $past(row_q) + 1'b1)); // R2
  AST_FRAME_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_wrap && !frame_last) |=> (frame_q == $past(frame_q) + 1'b1)); // R2
  AST_SUPER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    super_wrap |=> (frame_q == '0) && (row_q == '0) && (phase_q == '0)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(phase_q) && $stable(row_q) && $stable(frame_q)); // R10

endmodule

// File: rtl/sfm_cfg_regs.sv
module sfm_cfg_regs
  import sfm_pkg::*;
#(
  parameter int LVL_W     = 8,
  parameter int PANEL_RST = 128,
  parameter int DIGIT_RST = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we_i,
  input  logic [LVL_W-1:0] panel_i,
  input  logic [LVL_W-1:0] dig0_i,
  input  logic [LVL_W-1:0] dig1_i,
  input  logic             red_geo_i,
  input  logic             grn_geo_i,
  output logic [LVL_W-1:0] panel_o,
  output logic [LVL_W-1:0] dig0_o,
  output logic [LVL_W-1:0] dig1_o,
  output scale_e           red_sc_o,
  output scale_e           grn_sc_o
);

  logic [LVL_W-1:0] panel_q, dig0_q, dig1_q;
  scale_e           red_sc_q, grn_sc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      panel_q  <= LVL_W'(PANEL_RST);
      dig0_q   <= LVL_W'(DIGIT_RST);
      dig1_q   <= LVL_W'(DIGIT_RST);
      red_sc_q <= SCALE_ARITH;
      grn_sc_q <= SCALE_ARITH;
    end else if (cfg_we_i) begin
      panel_q  <= panel_i;
      dig0_q   <= dig0_i;
      dig1_q   <= dig1_i;
      red_sc_q <= scale_e'(red_geo_i);
      grn_sc_q <= scale_e'(grn_geo_i);
    end
  end

  assign panel_o  = panel_q;
  assign dig0_o   = dig0_q;
  assign dig1_o   = dig1_q;
  assign red_sc_o = red_sc_q;
  assign grn_sc_o = grn_sc_q;

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we_i |=> $stable(panel_q) && $stable(dig0_q) && $stable(dig1_q)
                  && $stable(red_sc_q) && $stable(grn_sc_q)); // R11
  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we_i |=> (panel_q == $past(panel_i)) && (dig0_q == $past(dig0_i))
                 && (dig1_q == $past(dig1_i))); // R11

endmodule

// File: rtl/sfm_level_cmp.sv
module sfm_level_cmp #(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] phase_i,
  input  logic [LVL_W-1:0] panel_i,
  input  logic [LVL_W-1:0] dig0_i,
  input  logic [LVL_W-1:0] dig1_i,
  output logic             gate_o,
  output logic [1:0]       dgate_o
);

  // floor(panel * digit / 2^LVL_W)
  function automatic logic [LVL_W-1:0] scale_level(input logic [LVL_W-1:0] panel,
                                                   input logic [LVL_W-1:0] digit);
    logic [2*LVL_W-1:0] prod;
    prod = {{LVL_W{1'b0}}, panel} * {{LVL_W{1'b0}}, digit};
    return prod[2*LVL_W-1:LVL_W];
  endfunction

  logic [LVL_W-1:0] eff0, eff1;

  assign eff0       = scale_level(panel_i, dig0_i);
  assign eff1       = scale_level(panel_i, dig1_i);
  assign gate_o     = (phase_i < panel_i);
  assign dgate_o[0] = (phase_i < eff0);
  assign dgate_o[1] = (phase_i < eff1);

  AST_DIGIT_WITHIN_PANEL: assert property (@(posedge clk) disable iff (!rst_n)
    (|dgate_o) |-> gate_o); // R8
  AST_ZERO_PANEL_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (panel_i == '0) |-> !gate_o && (dgate_o == 2'b00)); // R7

endmodule

// File: rtl/sfm_plane_lanes.sv
module sfm_plane_lanes
  import sfm_pkg::*;
#(
  parameter int COLS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               two_bit_i,
  input  logic [2*COLS-1:0]  code_i,
  input  scale_e             scale_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               dgate_i,
  output logic [COLS-1:0]    en_o
);

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [1:0] code_eff;
    logic       pat_on;

    // 1-bit mode: the low bit of the field stands for the whole code
    assign code_eff = two_bit_i ? code_i[2*c +: 2] : {2{code_i[2*c]}};
    assign pat_on   = frame_pattern(code_eff, scale_i, frame_i);
    assign en_o[c]  = pat_on & dgate_i;

    AST_CODE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (code_eff == 2'b00) |-> !en_o[c]); // R3
    AST_CODE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      ((code_eff == 2'b11) && dgate_i) |-> en_o[c]); // R3
    AST_ONE_BIT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (!two_bit_i && dgate_i) |-> (en_o[c] == code_i[2*c])); // R9
  end

  AST_DARK_OUTSIDE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !dgate_i |-> (en_o == '0)); // R8

endmodule

// File: rtl/superframe_modulator.sv
module superframe_modulator
  import sfm_pkg::*;
#(
  parameter int COLS      = 8,
  parameter int ROWS      = 8,
  parameter int LVL_W     = 8,
  parameter int PANEL_RST = 128,
  parameter int DIGIT_RST = 255
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     step_i,
  input  logic                     cfg_we_i,
  input  logic [LVL_W-1:0]         panel_lvl_i,
  input  logic [LVL_W-1:0]         dig0_scale_i,
  input  logic [LVL_W-1:0]         dig1_scale_i,
  input  logic                     red_geo_i,
  input  logic                     grn_geo_i,
  input  logic                     two_bit_i,
  input  logic [2*COLS-1:0]        red_code_i,
  input  logic [2*COLS-1:0]        grn_code_i,
  output logic [$clog2(ROWS)-1:0]  row_o,
  output logic [FRAME_W-1:0]       frame_o,
  output logic                     pwm_gate_o,
  output logic [COLS-1:0]          red_en_o,
  output logic [COLS-1:0]          grn_en_o
);

  logic [LVL_W-1:0]   phase;
  logic [FRAME_W-1:0] frame;
  logic [LVL_W-1:0]   panel, dig0, dig1;
  scale_e             red_sc, grn_sc;
  logic [1:0]         dgate;

  sfm_scan_ctr #(.PH_W(LVL_W), .ROWS(ROWS)) u_scan (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_i  (step_i),
    .phase_o (phase),
    .row_o   (row_o),
    .frame_o (frame)
  );

  sfm_cfg_regs #(.LVL_W(LVL_W), .PANEL_RST(PANEL_RST), .DIGIT_RST(DIGIT_RST)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we_i  (cfg_we_i),
    .panel_i   (panel_lvl_i),
    .dig0_i    (dig0_scale_i),
    .dig1_i    (dig1_scale_i),
    .red_geo_i (red_geo_i),
    .grn_geo_i (grn_geo_i),
    .panel_o   (panel),
    .dig0_o    (dig0),
    .dig1_o    (dig1),
    .red_sc_o  (red_sc),
    .grn_sc_o  (grn_sc)
  );

  sfm_level_cmp #(.LVL_W(LVL_W)) u_level (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_i (phase),
    .panel_i (panel),
    .dig0_i  (dig0),
    .dig1_i  (dig1),
    .gate_o  (pwm_gate_o),
    .dgate_o (dgate)
  );

  sfm_plane_lanes #(.COLS(COLS)) u_red (
    .clk       (clk),
    .rst_n     (rst_n),
    .two_bit_i (two_bit_i),
    .code_i    (red_code_i),
    .scale_i   (red_sc),
    .frame_i   (frame),
    .dgate_i   (dgate[0]),
    .en_o      (red_en_o)
  );

  sfm_plane_lanes #(.COLS(COLS)) u_grn (
    .clk       (clk),
    .rst_n     (rst_n),
    .two_bit_i (two_bit_i),
    .code_i    (grn_code_i),
    .scale_i   (grn_sc),
    .frame_i   (frame),
    .dgate_i   (dgate[1]),
    .en_o      (grn_en_o)
  );

  assign frame_o = frame;

  AST_ENABLE_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ((|red_en_o) || (|grn_en_o)) |-> pwm_gate_o); // R8

endmodule

// File: tb/superframe_modulator_bench.sv
module superframe_modulator_bench;

  localparam int COLS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_i = 1'b0, cfg_we_i = 1'b0;
  logic [7:0] panel_lvl_i = 8'd0, dig0_scale_i = 8'd0, dig1_scale_i = 8'd0;
  logic red_geo_i = 1'b0, grn_geo_i = 1'b0, two_bit_i = 1'b1;
  logic [2*COLS-1:0] red_code_i = '0, grn_code_i = '0;
  logic [2:0] row_o;
  logic [3:0] frame_o;
  logic pwm_gate_o;
  logic [COLS-1:0] red_en_o, grn_en_o;

  always #2 clk = ~clk; // 250 MHz

  superframe_modulator u_superframe_modulator (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .cfg_we_i(cfg_we_i),
    .panel_lvl_i(panel_lvl_i), .dig0_scale_i(dig0_scale_i), .dig1_scale_i(dig1_scale_i),
    .red_geo_i(red_geo_i), .grn_geo_i(grn_geo_i), .two_bit_i(two_bit_i),
    .red_code_i(red_code_i), .grn_code_i(grn_code_i),
    .row_o(row_o), .frame_o(frame_o), .pwm_gate_o(pwm_gate_o),
    .red_en_o(red_en_o), .grn_en_o(grn_en_o)
  );

  int checks = 0;
  int errors = 0;
  bit checking = 0;
  string en_tag = "R4";
  string st_tag = "R2";
  string gt_tag = "R7";

  // reference model state
  int m_ph = 0, m_row = 0, m_fr = 0;
  int m_panel = 128, m_d0 = 255, m_d1 = 255;
  bit m_rgeo = 0, m_ggeo = 0;

  // pattern bit f of the vector is frame f
  function automatic bit ref_on(input bit [1:0] code, input bit geo, input int fr);
    bit [11:0] tbl;
    case (code)
      2'b11: tbl = 12'hFFF;
      2'b00: tbl = 12'h000;
      2'b10: tbl = geo ? 12'b010101010101 : 12'b101101101101;
      default: tbl = geo ? 12'b001000100010 : 12'b010010010010;
    endcase
    return tbl[fr];
  endfunction

  function automatic bit [COLS-1:0] ref_en(input bit [2*COLS-1:0] codes, input bit geo,
                                           input int lvl);
    bit [COLS-1:0] r;
    for (int c = 0; c < COLS; c++) begin
      bit [1:0] cd;
      cd = two_bit_i ? codes[2*c +: 2] : {2{codes[2*c]}};
      r[c] = ref_on(cd, geo, m_fr) && (m_ph < lvl);
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_row = 0; m_fr = 0;
      m_panel = 128; m_d0 = 255; m_d1 = 255; m_rgeo = 0; m_ggeo = 0;
    end else begin
      if (step_i) begin
        m_ph = m_ph + 1;
        if (m_ph == 256) begin
          m_ph = 0;
          m_row = m_row + 1;
          if (m_row == 8) begin
            m_row = 0;
            m_fr = (m_fr + 1) % 12;
          end
        end
      end
      if (cfg_we_i) begin
        m_panel = panel_lvl_i; m_d0 = dig0_scale_i; m_d1 = dig1_scale_i;
        m_rgeo = red_geo_i; m_ggeo = grn_geo_i;
      end
    end
  end

  task automatic fail_line(input string tag, input string what, input int act, input int exp);
    errors++;
    $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
  endtask

  always @(negedge clk) begin
    if (checking) begin
      bit [COLS-1:0] er, eg;
      er = ref_en(red_code_i, m_rgeo, (m_panel * m_d0) / 256);
      eg = ref_en(grn_code_i, m_ggeo, (m_panel * m_d1) / 256);
      checks += 5;
      if (row_o != m_row[2:0]) fail_line(st_tag, "row", row_o, m_row);
      if (frame_o != m_fr[3:0]) fail_line(st_tag, "frame", frame_o, m_fr);
      if (pwm_gate_o != (m_ph < m_panel)) fail_line(gt_tag, "pwm_gate", pwm_gate_o, m_ph < m_panel);
      if (red_en_o != er) fail_line(en_tag, "red_en", red_en_o, er);
      if (grn_en_o != eg) fail_line(en_tag, "grn_en", grn_en_o, eg);
    end
  end

  // mode: 0 random codes, 1 codes only 00/11
  task automatic run(input int n, input int mode, input int step_pct, input int cfg_pct);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      red_code_i = 16'($urandom);
      grn_code_i = 16'($urandom);
      if (mode == 1) begin
        for (int c = 0; c < COLS; c++) begin
          red_code_i[2*c+1] = red_code_i[2*c];
          grn_code_i[2*c+1] = grn_code_i[2*c];
        end
      end
      step_i = ($urandom % 100) < step_pct;
      panel_lvl_i = 8'($urandom); dig0_scale_i = 8'($urandom); dig1_scale_i = 8'($urandom);
      red_geo_i = 1'($urandom); grn_geo_i = 1'($urandom);
      cfg_we_i = ($urandom % 1000) < cfg_pct;
      if (cfg_we_i && ($urandom % 4 == 0)) panel_lvl_i = ($urandom % 2) ? 8'd0 : 8'd255;
      if (cfg_we_i && ($urandom % 4 == 0)) dig0_scale_i = ($urandom % 2) ? 8'd255 : 8'd1;
    end
  endtask

  task automatic load_cfg(input int p, input int d0, input int d1, input bit rg, input bit gg);
    @(posedge clk); #1;
    panel_lvl_i = 8'(p); dig0_scale_i = 8'(d0); dig1_scale_i = 8'(d1);
    red_geo_i = rg; grn_geo_i = gg; cfg_we_i = 1'b1; step_i = 1'b0;
    @(posedge clk); #1;
    cfg_we_i = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state at the ports
    checks += 3;
    if (row_o != 3'd0) fail_line("R1", "row", row_o, 0);
    if (frame_o != 4'd0) fail_line("R1", "frame", frame_o, 0);
    if (pwm_gate_o != 1'b1) fail_line("R1", "pwm_gate", pwm_gate_o, 1);
    #1 rst_n = 1'b1;
    checking = 1;
    // R1 defaults with R4 arithmetic patterns over a full super frame
    en_tag = "R1/R4"; gt_tag = "R1/R7";
    run(24700, 0, 100, 0);
    // R5 and R6: red geometric, green arithmetic, full panel
    en_tag = "R5/R6"; gt_tag = "R7";
    load_cfg(255, 255, 200, 1'b1, 1'b0);
    run(24700, 0, 100, 0);
    // R3: only full/off codes, green geometric
    en_tag = "R3";
    load_cfg(200, 90, 255, 1'b0, 1'b1);
    run(24700, 1, 100, 0);
    // R9: 1-bit mode, noise on the ignored upper bits
    en_tag = "R9";
    @(posedge clk); #1 two_bit_i = 1'b0;
    run(8000, 0, 100, 0);
    @(posedge clk); #1 two_bit_i = 1'b1;
    // R10: stalls of the step strobe
    en_tag = "R10"; st_tag = "R10";
    run(20000, 0, 50, 0);
    // R11 and R8: config inputs churn, occasional loads incl. level corners
    en_tag = "R8/R11"; st_tag = "R2"; gt_tag = "R7/R11";
    run(25000, 0, 90, 8);
    checking = 0;
    summary();
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 195000, 0);
    summary();
    $finish;
  end

endmodule